// File: doc/BRIEF.md
# Parallel-Item Trace Enable Qualifier

This block sits between the address comparators and the trace encoder of a core that can retire several items in one cycle. Each cycle it sees a small group of slots, each holding either an instruction or a data transfer in the order they would be traced if run one at a time. Each slot carries a region-match bit and an event bit, for example the per-item state of a start/stop resource. From these it decides, once for the whole cycle, whether instruction trace and data trace are enabled.

Per-item answers are widened to cycle-wide answers, so every item that a one-at-a-time run would trace is still traced. Some neighbouring items in the same cycle may be traced as well, and that is accepted. In include mode any matching item of a kind enables that kind of trace. In exclude mode any item of a kind that falls outside the region enables it. The event is ORed over the instruction items of the cycle and gates data trace. Both enables are registered, so they appear one clock after the slot inputs.

A data slot belongs to the nearest valid instruction slot before it. Two data slots may therefore come from one load/store-multiple instruction on a wide data path. A build parameter selects a legacy mode in which at most one instruction per cycle may own data items.

Top module: `par_trace_qualifier`

## Requirements
- R1: While `rst_n` is low at a rising edge, both enables are 0 after that edge, whatever the slot inputs are.
- R2: With `region_exclude`=0 (include), `insn_trace_en` is 1 exactly when at least one valid slot with `slot_is_data`=0 has `slot_region_hit`=1.
- R3: With `region_exclude`=1 (exclude), `insn_trace_en` is 1 exactly when at least one valid slot with `slot_is_data`=0 has `slot_region_hit`=0.
- R4: Slots with `slot_valid`=0 have no effect on either enable. A cycle with no valid instruction slot gives `insn_trace_en`=0 in both modes.
- R5: The cycle event is 1 when any valid instruction slot has `slot_event`=1. Event bits on data slots or invalid slots are ignored. With the cycle event at 0, `data_trace_en` is 0.
- R6: In include mode, `data_trace_en` is the cycle event AND (at least one valid slot with `slot_is_data`=1 has `slot_region_hit`=1).
- R7: In exclude mode, `data_trace_en` is the cycle event AND (at least one valid slot with `slot_is_data`=1 has `slot_region_hit`=0).
- R8: Both enables are taken from the slot inputs sampled at the previous rising edge. There is no combinational path from the inputs to the outputs.
- R9: A valid data slot belongs to the nearest valid instruction slot before it. Two data slots owned by one instruction in a cycle are qualified like any others. When `SINGLE_XFER_INSN`=1, at most one instruction per cycle may be followed by its own data slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_valid | input | SLOTS | Slot holds an item this cycle; bit 0 is first in trace order |
| slot_is_data | input | SLOTS | 1 = data transfer item, 0 = instruction item |
| slot_region_hit | input | SLOTS | Item falls inside the configured region |
| slot_event | input | SLOTS | Per-item event resource state (read on instruction slots only) |
| region_exclude | input | 1 | 0 = include regions, 1 = exclude regions |
| insn_trace_en | output | 1 | Registered instruction trace enable for the cycle |
| data_trace_en | output | 1 | Registered data trace enable for the cycle |

## Verification
A wrong internal state would show as a wrong enable exactly one clock after the slot pattern that caused it. The register holds no history beyond that cycle, so an error never appears later or builds up. Typical faults are a mode select that is inverted, an invalid or wrong-kind slot that leaks into an OR reduction, or the event read from data slots. Each of these flips at least one enable for a specific slot pattern. A full sweep of a three-slot build therefore catches it the cycle after that pattern is applied. A missing output register shows up as an enable that changes before the clock edge.

// File: rtl/ptq_pkg.sv
// Package: shared types for the parallel-item trace enable qualifier.
// Assumes: slot index 0 is first in trace order.
package ptq_pkg;

    // Region interpretation selected by the mode input.
    typedef enum logic {
        MODE_INCLUDE = 1'b0,
        MODE_EXCLUDE = 1'b1
    } region_mode_e;

    // One cycle's qualification result.
    typedef struct packed {
        logic insn_en;
        logic data_en;
    } trace_qual_t;

endpackage

// File: rtl/ptq_slot_classify.sv
// Module: splits each slot into per-kind hit and miss flags and an
// instruction-event flag. Assumes invalid slots must contribute nothing.
module ptq_slot_classify #(
    parameter int SLOTS = 4
) (
    input  logic [SLOTS-1:0] valid,
    input  logic [SLOTS-1:0] is_data,
    input  logic [SLOTS-1:0] region_hit,
    input  logic [SLOTS-1:0] event_bit,
    output logic [SLOTS-1:0] insn_hit,
    output logic [SLOTS-1:0] insn_miss,
    output logic [SLOTS-1:0] data_hit,
    output logic [SLOTS-1:0] data_miss,
    output logic [SLOTS-1:0] insn_event
);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic live_insn;
        logic live_data;

        // Per-slot kind decode, gated by validity.
        always_comb begin
            live_insn     = valid[s] & ~is_data[s];
            live_data     = valid[s] &  is_data[s];
            insn_hit[s]   = live_insn &  region_hit[s];
            insn_miss[s]  = live_insn & ~region_hit[s];
            data_hit[s]   = live_data &  region_hit[s];
            data_miss[s]  = live_data & ~region_hit[s];
            insn_event[s] = live_insn &  event_bit[s];
        end
    end

endmodule

// File: rtl/ptq_region_select.sv
// Module: reduces per-slot hit/miss flags of one item kind to a cycle-wide
// region decision. Include mode takes any hit, exclude mode any miss.
module ptq_region_select #(
    parameter int SLOTS = 4
) (
    input  ptq_pkg::region_mode_e mode,
    input  logic [SLOTS-1:0]      hit,
    input  logic [SLOTS-1:0]      miss,
    output logic                  pass
);

    import ptq_pkg::*;

    // Widen per-item matches to the whole cycle.
    always_comb begin
        if (mode == MODE_EXCLUDE) pass = |miss;
        else                      pass = |hit;
    end

endmodule

// File: rtl/ptq_qual_reg.sv
// Module: output register of the qualifier with synchronous active-low reset.
module ptq_qual_reg (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ptq_pkg::trace_qual_t d,
    output ptq_pkg::trace_qual_t q
);

    // Capture the cycle decision; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/par_trace_qualifier.sv
// Module: top of the parallel-item trace enable qualifier. Takes a group of
// items retired in one cycle and gives registered cycle-wide instruction and
// data trace enables, so that no item traced in a one-at-a-time run is lost.
// Assumes: slots are presented in trace order, an instruction slot comes
// before its data slots, and comparator results are already per slot.
module par_trace_qualifier #(
    parameter int SLOTS            = 4,
    parameter bit SINGLE_XFER_INSN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] slot_valid,
    input  logic [SLOTS-1:0] slot_is_data,
    input  logic [SLOTS-1:0] slot_region_hit,
    input  logic [SLOTS-1:0] slot_event,
    input  logic             region_exclude,
    output logic             insn_trace_en,
    output logic             data_trace_en
);

    import ptq_pkg::*;

    logic [SLOTS-1:0] insn_hit, insn_miss, data_hit, data_miss, insn_event;
    logic             insn_pass, data_pass, cycle_event;
    region_mode_e     mode;
    trace_qual_t      qual_d, qual_q;

    // Mode bit to typed region mode.
    always_comb mode = region_mode_e'(region_exclude);

    ptq_slot_classify #(.SLOTS(SLOTS)) u_classify (
        .valid      (slot_valid),
        .is_data    (slot_is_data),
        .region_hit (slot_region_hit),
        .event_bit  (slot_event),
        .insn_hit   (insn_hit),
        .insn_miss  (insn_miss),
        .data_hit   (data_hit),
        .data_miss  (data_miss),
        .insn_event (insn_event)
    );

    ptq_region_select #(.SLOTS(SLOTS)) u_insn_sel (
        .mode (mode),
        .hit  (insn_hit),
        .miss (insn_miss),
        .pass (insn_pass)
    );

    ptq_region_select #(.SLOTS(SLOTS)) u_data_sel (
        .mode (mode),
        .hit  (data_hit),
        .miss (data_miss),
        .pass (data_pass)
    );

    // Event counts for the whole cycle if any instruction raised it.
    always_comb cycle_event = |insn_event;

    // Combine region and event decisions into the next cycle result.
    always_comb begin
        qual_d.insn_en = insn_pass;
        qual_d.data_en = data_pass & cycle_event;
    end

    ptq_qual_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (qual_d),
        .q     (qual_q)
    );

    // Drive ports from the register.
    always_comb begin
        insn_trace_en = qual_q.insn_en;
        data_trace_en = qual_q.data_en;
    end

endmodule

// File: rtl/ptq_checker.sv
// Module: property checker for par_trace_qualifier, attached by bind.
// Assumes: ports mirror the top; reads no internal signals.
module ptq_checker #(
    parameter int SLOTS            = 4,
    parameter bit SINGLE_XFER_INSN = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SLOTS-1:0] slot_valid,
    input logic [SLOTS-1:0] slot_is_data,
    input logic [SLOTS-1:0] slot_region_hit,
    input logic [SLOTS-1:0] slot_event,
    input logic             region_exclude,
    input logic             insn_trace_en,
    input logic             data_trace_en
);

    logic [SLOTS-1:0] vi, vd;
    logic             seen = 1'b0;
    logic             rst_q = 1'b0;
    int               owners;

    // Valid instruction and valid data slot vectors.
    always_comb begin
        vi = slot_valid & ~slot_is_data;
        vd = slot_valid &  slot_is_data;
    end

    // Count instructions that own at least one following data slot.
    always_comb begin
        logic last_insn;
        owners    = 0;
        last_insn = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (vi[s]) last_insn = 1'b1;
            else if (vd[s]) begin
                if (last_insn) owners++;
                last_insn = 1'b0;
            end
        end
    end

    // Track the reset level seen at the previous edge.
    always_ff @(posedge clk) begin
        seen  <= 1'b1;
        rst_q <= rst_n;
    end

    // R1: outputs cleared after an edge with reset asserted.
    always_ff @(posedge clk) begin
        if (seen && !rst_q)
            p_reset_quiet_r1: assert (!insn_trace_en && !data_trace_en);
    end

    p_include_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!region_exclude && |(vi & slot_region_hit)) |=> insn_trace_en);

    p_exclude_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (region_exclude && |(vi & ~slot_region_hit)) |=> insn_trace_en);

    p_no_insn_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vi == '0) |=> !insn_trace_en);

    p_data_needs_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((vi & slot_event) == '0) |=> !data_trace_en);

    p_no_data_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vd == '0) |=> !data_trace_en);

    p_exclude_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (region_exclude && |(vi & slot_event) && |(vd & ~slot_region_hit))
        |=> data_trace_en);

    if (SINGLE_XFER_INSN) begin : g_single
        p_single_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
            owners <= 1);
    end

endmodule

bind par_trace_qualifier ptq_checker #(
    .SLOTS            (SLOTS),
    .SINGLE_XFER_INSN (SINGLE_XFER_INSN)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .slot_valid      (slot_valid),
    .slot_is_data    (slot_is_data),
    .slot_region_hit (slot_region_hit),
    .slot_event      (slot_event),
    .region_exclude  (region_exclude),
    .insn_trace_en   (insn_trace_en),
    .data_trace_en   (data_trace_en)
);

// File: tb/par_trace_qualifier_tb.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of a three-slot build plus reset, latency and
// paired-data cases. Expected enables are computed from the requirements.
module par_trace_qualifier_tb;

    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] valid = '0, isd = '0, hit = '0, evt = '0;
    logic         excl = 1'b0;
    logic         insn_en, data_en;
    int           checks = 0, fails = 0;
    bit           done = 0;

    always #10 clk = ~clk;

    par_trace_qualifier #(.SLOTS(N), .SINGLE_XFER_INSN(1'b1)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .slot_valid      (valid),
        .slot_is_data    (isd),
        .slot_region_hit (hit),
        .slot_event      (evt),
        .region_exclude  (excl),
        .insn_trace_en   (insn_en),
        .data_trace_en   (data_en)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Expected enables from the requirement formulas.
    function automatic logic [1:0] model(input logic [N-1:0] v, d, h, e,
                                         input logic x);
        logic ih = 0, im = 0, dh = 0, dm = 0, ev = 0;
        for (int s = 0; s < N; s++) begin
            if (v[s] && !d[s]) begin
                ih |= h[s]; im |= !h[s]; ev |= e[s];
            end
            if (v[s] && d[s]) begin
                dh |= h[s]; dm |= !h[s];
            end
        end
        model[1] = x ? im : ih;
        model[0] = ev & (x ? dm : dh);
    endfunction

    initial begin
        logic [1:0] exp_q;
        logic       have;
        string      ri, rd;
        // R1: reset holds outputs low even with hitting inputs.
        valid = 3'b011; isd = 3'b010; hit = 3'b011; evt = 3'b001;
        repeat (3) @(negedge clk);
        chk("R1 insn", insn_en, 1'b0);
        chk("R1 data", data_en, 1'b0);
        valid = '0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 idle insn", insn_en, 1'b0);

        // R8: new pattern must not reach outputs before the clock edge.
        valid = 3'b011; isd = 3'b010; hit = 3'b011; evt = 3'b001; excl = 0;
        #1;
        chk("R8 no comb insn", insn_en, 1'b0);
        chk("R8 no comb data", data_en, 1'b0);
        @(negedge clk);
        chk("R8 one cycle insn", insn_en, 1'b1);
        chk("R8 one cycle data", data_en, 1'b1);

        // R9: one instruction with two data items from a wide transfer.
        valid = 3'b111; isd = 3'b110; hit = 3'b100; evt = 3'b001; excl = 0;
        @(negedge clk);
        chk("R9 paired data include", data_en, 1'b1);
        valid = 3'b111; isd = 3'b110; hit = 3'b011; evt = 3'b001; excl = 1;
        @(negedge clk);
        chk("R9 paired data exclude", data_en, 1'b1);
        // R5: event only on data slots is ignored.
        valid = 3'b011; isd = 3'b010; hit = 3'b011; evt = 3'b010; excl = 0;
        @(negedge clk);
        chk("R5 data-slot event ignored", data_en, 1'b0);

        // Exhaustive sweep, pipelined by one cycle.
        have = 0;
        for (int c = 0; c < (1 << (4*N+1)); c++) begin
            if (have) begin
                chk(ri, insn_en, exp_q[1]);
                chk(rd, data_en, exp_q[0]);
            end
            {excl, evt, hit, isd, valid} = c[4*N:0];
            exp_q = model(valid, isd, hit, evt, excl);
            ri = ((valid & ~isd) == '0) ? "R4 insn" : (excl ? "R3 insn" : "R2 insn");
            rd = ((valid & ~isd & evt) == '0) ? "R5 data" : (excl ? "R7 data" : "R6 data");
            have = 1;
            @(negedge clk);
        end
        chk(ri, insn_en, exp_q[1]);
        chk(rd, data_en, exp_q[0]);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

endmodule